// File: doc/BRIEF.md
# Debounced Input Port with Key-Combination Reset

This block is an eight-pin general-purpose input port. The pad levels are first synchronized to the peripheral clock. Each pin can then be masked by its enable bit. The pins form two nibble-wide groups. Each group passes through its own debounce filter, and the filter's settle time is chosen from a set of power-of-two values or bypassed. The filtered, enabled levels are presented on `pin_data_o`.

A key-combination detector watches the filtered low-order pins. When a selected group of them is held low together, it raises a reset request for the system reset controller. The request falls as soon as any selected pin goes high again.

Software reaches the block over a small synchronous register bus. Three byte registers hold the settings: the filter codes at offset 0, the key-reset mode at offset 1 and the pin enables at offset 2. Reads return data combinationally from the address. Writes take effect on the clock edge on which `bus_we_i` is high.

Top module: `gpio_kr_port`

## Requirements
- R1: After reset, offset 0 reads 0x00, offset 1 reads 0x00 and offset 2 reads 0xFF. Any other offset reads 0x00.
- R2: At offset 0, bits 2:0 hold the filter code for pins 3:0 and bits 6:4 hold the code for pins 7:4; bits 7 and 3 read 0. At offset 1, bits 1:0 hold the key mode and bits 7:2 read 0.
- R3: With filter code 0, a pad change appears on `pin_data_o` exactly three clock edges after the pad is sampled: two synchronizer stages plus one output register.
- R4: With filter code n (1 to 7), the settle time S is 2^(MIN_SHIFT+n-1) clocks, which is 256 to 16384 at the default setting. A steady pad change reaches `pin_data_o` on the (S+3)-th clock edge after it is first sampled, and not before.
- R5: If a group's input returns to its current filtered value, or changes again, before the settle time has elapsed, the count starts over. A glitch shorter than S never reaches the output.
- R6: The two groups filter independently, each with its own code and counter.
- R7: A pin whose enable bit at offset 2 is 0 reads 0 on `pin_data_o` from the edge on which the enable bit is cleared.
- R8: Key mode 0 never requests reset. Modes 1, 2 and 3 raise `key_rst_req_o` one edge after filtered pins 1:0, 2:0 or 3:0 respectively are all low.
- R9: `key_rst_req_o` falls one edge after any selected filtered pin reads high.
- R10: Writing a changed filter code to a group restarts that group's settle count and leaves its filtered value unchanged on that edge.
- R11: Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 4 | Register byte offset |
| bus_wdata_i | input | 8 | Write data |
| bus_we_i | input | 1 | Write strobe |
| bus_rdata_o | output | 8 | Read data for the addressed offset |
| pad_i | input | 8 | Raw pad levels |
| pin_data_o | output | 8 | Filtered, enabled pin levels |
| key_rst_req_o | output | 1 | Key-combination reset request |

## Verification
The bench builds the port with MIN_SHIFT set to 2. This shrinks the settle times to 4 clocks for code 1 and 256 clocks for code 7, so every filter code, including the longest, can be timed to the exact edge within a short run. All other parameters keep their defaults. With the times this short, the bench can also time the counter restart on a code change and the independence of a slow group from a bypassed one.

// File: rtl/gpio_kr_pkg.sv
package gpio_kr_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned OFS_FILT = 0;
  localparam int unsigned OFS_KEY  = 1;
  localparam int unsigned OFS_IEN  = 2;

  typedef enum logic [1:0] {
    KEY_OFF   = 2'd0,
    KEY_LOW2  = 2'd1,
    KEY_LOW3  = 2'd2,
    KEY_LOW4  = 2'd3
  } key_mode_e;
endpackage

// File: rtl/gpio_kr_rstsync.sv
module gpio_kr_rstsync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_no = stage_q[1];
endmodule

// File: rtl/gpio_kr_sync.sv
module gpio_kr_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/gpio_kr_debounce.sv
module gpio_kr_debounce #(
  parameter int unsigned GW        = 4,
  parameter int unsigned CODE_W    = 3,
  parameter int unsigned MIN_SHIFT = 8,
  localparam int unsigned CNT_W    = MIN_SHIFT + (1 << CODE_W) - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              restart_i,
  input  logic [GW-1:0]     in_i,
  output logic [GW-1:0]     filt_o
);
  logic [GW-1:0]    samp_q, samp_d;
  logic [GW-1:0]    filt_q, filt_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] limit;

  // last count value before the output may move
  always_comb begin
    if (code_i == '0) limit = '0;
    else limit = CNT_W'((32'd1 << (MIN_SHIFT + 32'(code_i) - 32'd1)) - 32'd1);
  end

  always_comb begin
    samp_d = in_i;
    filt_d = filt_q;
    cnt_d  = cnt_q;
    if (restart_i) begin
      cnt_d = '0;
    end else if (code_i == '0) begin
      filt_d = in_i;
      cnt_d  = '0;
    end else if ((in_i != samp_q) || (in_i == filt_q)) begin
      cnt_d = '0;
    end else if (cnt_q == limit) begin
      filt_d = in_i;
      cnt_d  = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q <= '0;
      filt_q <= '0;
      cnt_q  <= '0;
    end else begin
      samp_q <= samp_d;
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign filt_o = filt_q;

  p_follow_input_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt_q) |-> (filt_q == $past(in_i)));
  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q <= limit));
  p_restart_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> ((cnt_q == '0) && $stable(filt_q)));
endmodule

// File: rtl/gpio_kr_keydet.sv
module gpio_kr_keydet
  import gpio_kr_pkg::*;
#(
  parameter int unsigned NP = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  key_mode_e     mode_i,
  input  logic [NP-1:0] pins_i,
  output logic          req_o
);
  logic [NP-1:0] sel;
  logic          req_d, req_q;

  for (genvar j = 0; j < NP; j++) begin : g_sel
    assign sel[j] = (mode_i != KEY_OFF) && (32'(j) <= 32'(mode_i));
  end

  assign req_d = (mode_i != KEY_OFF) && ((pins_i & sel) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= req_d;
  end

  assign req_o = req_q;

  p_off_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == KEY_OFF) |=> !req_q);
  p_drop_high_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == KEY_LOW2) && (pins_i[0] || pins_i[1])) |=> !req_q);
endmodule

// File: rtl/gpio_kr_port.sv
module gpio_kr_port
  import gpio_kr_pkg::*;
#(
  parameter int unsigned GROUP_W   = 4,
  parameter int unsigned NGROUPS   = 2,
  parameter int unsigned CODE_W    = 3,
  parameter int unsigned MIN_SHIFT = 8,
  parameter int unsigned ADDR_W    = 4,
  localparam int unsigned NPINS    = GROUP_W * NGROUPS,
  localparam int unsigned KEY_W    = 2,
  localparam int unsigned KEY_NP   = 1 << KEY_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BYTE_W-1:0] bus_wdata_i,
  input  logic              bus_we_i,
  output logic [BYTE_W-1:0] bus_rdata_o,
  input  logic [NPINS-1:0]  pad_i,
  output logic [NPINS-1:0]  pin_data_o,
  output logic              key_rst_req_o
);
  logic rst_n;

  logic [NGROUPS-1:0][CODE_W-1:0] code_q, code_d;
  key_mode_e                      key_q, key_d;
  logic [NPINS-1:0]               ien_q, ien_d;
  logic [NGROUPS-1:0]             restart;
  logic                           hit_filt, hit_key, hit_ien, unmapped;

  logic [NPINS-1:0] pad_sync;
  logic [NPINS-1:0] gated;
  logic [NPINS-1:0] filt;

  gpio_kr_rstsync u_rstsync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  gpio_kr_sync #(.W(NPINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .d_i    (pad_i),
    .q_o    (pad_sync)
  );

  // address decode
  assign hit_filt = (bus_addr_i == ADDR_W'(OFS_FILT));
  assign hit_key  = (bus_addr_i == ADDR_W'(OFS_KEY));
  assign hit_ien  = (bus_addr_i == ADDR_W'(OFS_IEN));
  assign unmapped = !(hit_filt || hit_key || hit_ien);

  always_comb begin
    code_d  = code_q;
    key_d   = key_q;
    ien_d   = ien_q;
    restart = '0;
    if (bus_we_i && hit_filt) begin
      for (int g = 0; g < NGROUPS; g++) begin
        code_d[g]  = bus_wdata_i[g*GROUP_W +: CODE_W];
        restart[g] = (code_d[g] != code_q[g]);
      end
    end
    if (bus_we_i && hit_key) key_d = key_mode_e'(bus_wdata_i[KEY_W-1:0]);
    if (bus_we_i && hit_ien) ien_d = bus_wdata_i[NPINS-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      key_q  <= KEY_OFF;
      ien_q  <= '1;
    end else begin
      code_q <= code_d;
      key_q  <= key_d;
      ien_q  <= ien_d;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (hit_filt) begin
      for (int g = 0; g < NGROUPS; g++) bus_rdata_o[g*GROUP_W +: CODE_W] = code_q[g];
    end else if (hit_key) begin
      bus_rdata_o[KEY_W-1:0] = key_q;
    end else if (hit_ien) begin
      bus_rdata_o[NPINS-1:0] = ien_q;
    end
  end

  assign gated = pad_sync & ien_q;

  for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
    gpio_kr_debounce #(
      .GW        (GROUP_W),
      .CODE_W    (CODE_W),
      .MIN_SHIFT (MIN_SHIFT)
    ) u_deb (
      .clk_i     (clk_i),
      .rst_ni    (rst_n),
      .code_i    (code_q[g]),
      .restart_i (restart[g]),
      .in_i      (gated[g*GROUP_W +: GROUP_W]),
      .filt_o    (filt[g*GROUP_W +: GROUP_W])
    );
  end

  assign pin_data_o = filt & ien_q;

  gpio_kr_keydet #(.NP(KEY_NP)) u_keydet (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .mode_i (key_q),
    .pins_i (pin_data_o[KEY_NP-1:0]),
    .req_o  (key_rst_req_o)
  );

  p_unmapped_r11: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_we_i && unmapped) |=> ($stable(code_q) && $stable(key_q) && $stable(ien_q)));
  p_rsv_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    hit_filt |-> (bus_rdata_o[7] == 1'b0 && bus_rdata_o[3] == 1'b0));
  p_key_rsv_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    hit_key |-> (bus_rdata_o[7:2] == '0));
endmodule

// File: tb/gpio_kr_port_bench.sv
module gpio_kr_port_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] addr;
  logic [7:0] wdata;
  logic       we;
  logic [7:0] rdata;
  logic [7:0] pads;
  logic [7:0] pdata;
  logic       kreq;
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  gpio_kr_port #(.MIN_SHIFT(2)) u_gpio_kr_port (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .bus_addr_i    (addr),
    .bus_wdata_i   (wdata),
    .bus_we_i      (we),
    .bus_rdata_o   (rdata),
    .pad_i         (pads),
    .pin_data_o    (pdata),
    .key_rst_req_o (kreq)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    tick(1);
    we = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [3:0] a, input logic [7:0] exp);
    addr = a;
    #1;
    check8(req, rdata, exp);
  endtask

  function automatic int settle(input int code);
    return 1 << (2 + code - 1);
  endfunction

  task automatic t_reset();
    rd_check("R1", 4'd0, 8'h00);
    rd_check("R1", 4'd1, 8'h00);
    rd_check("R1", 4'd2, 8'hFF);
    rd_check("R1", 4'd3, 8'h00);
    rd_check("R1", 4'd15, 8'h00);
    check8("R1", pdata, 8'hFF);
    check8("R1", {7'd0, kreq}, 8'h00);
  endtask

  task automatic t_layout();
    wr(4'd0, 8'hFF);
    rd_check("R2", 4'd0, 8'h77);
    wr(4'd0, 8'h25);
    rd_check("R2", 4'd0, 8'h25);
    wr(4'd1, 8'hFF);
    rd_check("R2", 4'd1, 8'h03);
    wr(4'd1, 8'h00);
    wr(4'd0, 8'h00);
    tick(5);
  endtask

  task automatic t_bypass();
    pads = 8'h5A;
    tick(2);
    check8("R3", pdata, 8'hFF);
    tick(1);
    check8("R3", pdata, 8'h5A);
    pads = 8'hFF;
    tick(5);
  endtask

  task automatic t_settle(input int code);
    int s = settle(code);
    wr(4'd0, 8'(code));
    tick(5);
    pads = 8'hF0;
    tick(s + 2);
    check8("R4", pdata, 8'hFF);
    tick(1);
    check8("R4", pdata, 8'hF0);
    pads = 8'hFF;
    tick(s + 2);
    check8("R4", pdata, 8'hF0);
    tick(1);
    check8("R4", pdata, 8'hFF);
    wr(4'd0, 8'h00);
    tick(5);
  endtask

  task automatic t_bounce();
    int s = settle(2);
    wr(4'd0, 8'h02);
    tick(5);
    pads = 8'hF0;
    tick(5);
    pads = 8'hFF;
    tick(1);
    pads = 8'hF0;
    tick(s + 2);
    check8("R5", pdata, 8'hFF);
    tick(1);
    check8("R5", pdata, 8'hF0);
    pads = 8'hFF;
    tick(s + 3);
    pads = 8'hF5;
    tick(s - 2);
    pads = 8'hFF;
    tick(3 * s);
    check8("R5", pdata, 8'hFF);
    wr(4'd0, 8'h00);
    tick(5);
  endtask

  task automatic t_groups();
    int s = settle(7);
    wr(4'd0, 8'h70);
    tick(5);
    pads = 8'h00;
    tick(3);
    check8("R6", pdata, 8'hF0);
    tick(s - 1);
    check8("R6", pdata, 8'hF0);
    tick(1);
    check8("R6", pdata, 8'h00);
    wr(4'd0, 8'h00);
    pads = 8'hFF;
    tick(5);
    check8("R6", pdata, 8'hFF);
  endtask

  task automatic t_restart();
    wr(4'd0, 8'h30);
    tick(5);
    pads = 8'h0F;
    tick(10);
    wr(4'd0, 8'h40);
    check8("R10", pdata, 8'hFF);
    tick(31);
    check8("R10", pdata, 8'hFF);
    tick(1);
    check8("R10", pdata, 8'h0F);
    wr(4'd0, 8'h00);
    pads = 8'hFF;
    tick(5);
  endtask

  task automatic t_enable();
    wr(4'd2, 8'h0F);
    check8("R7", pdata, 8'h0F);
    pads = 8'hAF;
    tick(6);
    check8("R7", pdata, 8'h0F);
    wr(4'd2, 8'hFF);
    pads = 8'hFF;
    tick(5);
    check8("R7", pdata, 8'hFF);
  endtask

  task automatic t_key();
    pads = 8'hFC;
    tick(5);
    wr(4'd1, 8'h01);
    tick(1);
    check8("R8", {7'd0, kreq}, 8'h01);
    wr(4'd1, 8'h02);
    tick(1);
    check8("R8", {7'd0, kreq}, 8'h00);
    pads = 8'hF8;
    tick(5);
    check8("R8", {7'd0, kreq}, 8'h01);
    wr(4'd1, 8'h03);
    tick(1);
    check8("R8", {7'd0, kreq}, 8'h00);
    pads = 8'hF0;
    tick(5);
    check8("R8", {7'd0, kreq}, 8'h01);
    pads = 8'hF8;
    tick(3);
    check8("R9", {7'd0, kreq}, 8'h01);
    tick(1);
    check8("R9", {7'd0, kreq}, 8'h00);
    pads = 8'hF0;
    tick(5);
    wr(4'd1, 8'h00);
    tick(1);
    check8("R8", {7'd0, kreq}, 8'h00);
    pads = 8'hFF;
    tick(5);
  endtask

  task automatic t_unmapped();
    wr(4'd0, 8'h21);
    wr(4'd3, 8'h55);
    wr(4'd9, 8'hAA);
    rd_check("R11", 4'd0, 8'h21);
    rd_check("R11", 4'd1, 8'h00);
    rd_check("R11", 4'd2, 8'hFF);
    rd_check("R11", 4'd3, 8'h00);
    wr(4'd0, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; addr = '0; wdata = '0; we = 1'b0; pads = 8'hFF;
    tick(5);
    rst_n = 1'b1;
    tick(10);
    t_reset();
    t_layout();
    t_bypass();
    t_settle(1);
    t_settle(3);
    t_bounce();
    t_groups();
    t_restart();
    t_enable();
    t_key();
    t_unmapped();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule